// File: doc/BRIEF.md
# Packed-lane shift-left unit with sticky overflow flag

The block shifts a 32-bit word left by an immediate amount, treating the word as a set of independent packed lanes. In halfword mode the word holds two 16-bit signed lanes. In byte mode it holds four 8-bit unsigned lanes. Each lane is shifted on its own. Zeros enter from the right, and bits that leave a lane are dropped instead of passing into the next lane up.

Each operation reports whether any of its lanes overflowed, and the test differs with the lane type. A signed halfword lane overflows when the shifted value no longer fits in 16 signed bits. This includes the case where only the sign bit changes. An unsigned byte lane overflows only when a one bit is shifted out.

An overflow sets a sticky flag at bit 22 of a 32-bit control/status word. Software can write and read that word through a plain register port. The usual sequence is to write zero, issue the shift, and then read the word back.

Top module: `simd_shl_unit`

## Requirements
- R1: While reset is asserted and after it is released, `res_valid` is 0 and `csr_rd_data` is 0x00000000.
- R2: `res_valid` is high for exactly one cycle, in the cycle after `op_valid` is sampled high. `res_data` carries that operation's result and holds its value until the next operation completes.
- R3: With `op_mode`=0 (halfword), bits [31:16] and [15:0] are each shifted left by `op_shamt` (0 to 15). Zeros fill from the right, and no bit crosses from one lane into the other.
- R4: With `op_mode`=1 (byte), bytes [31:24], [23:16], [15:8] and [7:0] are each shifted left by `op_shamt[2:0]`. `op_shamt[3]` is ignored, zeros fill each byte from the right, and no bit crosses a byte boundary.
- R5: A halfword lane overflows when its top `op_shamt`+1 input bits are not all equal. Two examples: 0x7FFF8000 shifted by 1 gives 0xFFFE0000 with overflow, and 0x00000001 shifted by 15 gives 0x00008000 with overflow.
- R6: A byte lane overflows when any of its top `op_shamt[2:0]` input bits is 1. Two examples: 0x00000001 shifted by 7 gives 0x00000080 with no overflow, and 0x87654321 shifted by 3 gives 0x38281808 with overflow.
- R7: If any lane of an operation overflows, bit 22 of `csr_rd_data` is 1 in the cycle `res_valid` is high. A shift amount of 0 never causes overflow.
- R8: Bit 22 is sticky. An operation only ever sets it, only a register write clears it, and operations never change the other 31 bits.
- R9: When `csr_wr_en` is high, the register takes `csr_wr_data` in the next cycle. If an overflowing operation is sampled in the same cycle, bit 22 is also set.
- R10: `csr_rd_data` always shows the current register contents, without waiting for any read strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | Start a shift this cycle |
| op_mode | input | 1 | Lane layout: 0 = two halfwords, 1 = four bytes |
| op_shamt | input | 4 | Immediate shift amount |
| op_src | input | 32 | Operand word |
| res_valid | output | 1 | Result strobe, one cycle after `op_valid` |
| res_data | output | 32 | Shifted word |
| csr_wr_en | input | 1 | Write strobe for the control/status word |
| csr_wr_data | input | 32 | Value to write |
| csr_rd_data | output | 32 | Current control/status word; bit 22 is the overflow flag |

## Verification
Every shift result and its overflow flag become visible together, one clock edge after `op_valid` is sampled. The driver pushes the expected word and the expected full control/status value into a queue at the falling edge where it presents the operation. The monitor pops that entry at the next falling edge, which is when `res_valid` is high, and compares both values. A register write shows up on `csr_rd_data` one edge after its strobe and is checked at the following falling edge. Quiet cycles after a result are checked to confirm that the strobe has dropped and that the data word has held.

// File: rtl/simd_shl_pkg.sv
package simd_shl_pkg;

  typedef enum logic {
    LAYOUT_HALF = 1'b0,
    LAYOUT_BYTE = 1'b1
  } shl_layout_e;

endpackage

// File: rtl/simd_shl_lane.sv
module simd_shl_lane #(
  parameter int LANE_W     = 16,
  parameter bit SIGNED_CHK = 1'b1,
  localparam int SH_W      = $clog2(LANE_W)
) (
  input  logic [LANE_W-1:0] din,
  input  logic [SH_W-1:0]   sh,
  output logic [LANE_W-1:0] dout,
  output logic              ovf
);

  function automatic logic [LANE_W-1:0] lane_shift(input logic [LANE_W-1:0] v,
                                                   input logic [SH_W-1:0] s);
    return v << s;
  endfunction

  // top s+1 bits must all match the sign bit
  function automatic logic sign_lost(input logic [LANE_W-1:0] v,
                                     input logic [SH_W-1:0] s);
    logic r;
    r = 1'b0;
    for (int i = 0; i < LANE_W; i++) begin
      if ((i >= (LANE_W - 1) - int'(s)) && (v[i] != v[LANE_W-1])) r = 1'b1;
    end
    return r;
  endfunction

  // any one among the top s bits is lost
  function automatic logic ones_lost(input logic [LANE_W-1:0] v,
                                     input logic [SH_W-1:0] s);
    logic r;
    r = 1'b0;
    for (int i = 0; i < LANE_W; i++) begin
      if ((i >= LANE_W - int'(s)) && v[i]) r = 1'b1;
    end
    return r;
  endfunction

  assign dout = lane_shift(din, sh);

  generate
    if (SIGNED_CHK) begin : g_signed
      assign ovf = sign_lost(din, sh);
    end else begin : g_unsigned
      assign ovf = ones_lost(din, sh);
    end
  endgenerate

endmodule

// File: rtl/simd_shl_csr.sv
module simd_shl_csr #(
  parameter int DATA_W  = 32,
  parameter int OVF_POS = 22
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              set_ovf,
  output logic [DATA_W-1:0] q
);

  logic [DATA_W-1:0] base;
  logic [DATA_W-1:0] next_q;

  always_comb begin
    base   = wr_en ? wr_data : q;
    next_q = base;
    if (set_ovf) next_q[OVF_POS] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= next_q;
  end

endmodule

// File: rtl/simd_shl_unit.sv
module simd_shl_unit #(
  parameter int DATA_W  = 32,
  parameter int HALF_W  = 16,
  parameter int BYTE_W  = 8,
  parameter int OVF_POS = 22,
  localparam int N_HALF = DATA_W / HALF_W,
  localparam int N_BYTE = DATA_W / BYTE_W,
  localparam int SH_W   = $clog2(HALF_W),
  localparam int BSH_W  = $clog2(BYTE_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              op_valid,
  input  logic              op_mode,
  input  logic [SH_W-1:0]   op_shamt,
  input  logic [DATA_W-1:0] op_src,
  output logic              res_valid,
  output logic [DATA_W-1:0] res_data,
  input  logic              csr_wr_en,
  input  logic [DATA_W-1:0] csr_wr_data,
  output logic [DATA_W-1:0] csr_rd_data
);
  import simd_shl_pkg::*;

  logic [DATA_W-1:0] half_word;
  logic [DATA_W-1:0] byte_word;
  logic [N_HALF-1:0] half_ovf;
  logic [N_BYTE-1:0] byte_ovf;
  shl_layout_e       layout;
  logic [DATA_W-1:0] sel_word;
  logic              sel_ovf;
  logic              op_ovf_event;

  generate
    for (genvar h = 0; h < N_HALF; h++) begin : g_half
      simd_shl_lane #(.LANE_W(HALF_W), .SIGNED_CHK(1'b1)) u_lane (
        .din  (op_src[h*HALF_W +: HALF_W]),
        .sh   (op_shamt),
        .dout (half_word[h*HALF_W +: HALF_W]),
        .ovf  (half_ovf[h])
      );
    end
    for (genvar b = 0; b < N_BYTE; b++) begin : g_byte
      simd_shl_lane #(.LANE_W(BYTE_W), .SIGNED_CHK(1'b0)) u_lane (
        .din  (op_src[b*BYTE_W +: BYTE_W]),
        .sh   (op_shamt[BSH_W-1:0]),
        .dout (byte_word[b*BYTE_W +: BYTE_W]),
        .ovf  (byte_ovf[b])
      );
    end
  endgenerate

  always_comb begin
    layout = shl_layout_e'(op_mode);
    if (layout == LAYOUT_BYTE) begin
      sel_word = byte_word;
      sel_ovf  = |byte_ovf;
    end else begin
      sel_word = half_word;
      sel_ovf  = |half_ovf;
    end
  end

  assign op_ovf_event = op_valid & sel_ovf;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      res_data  <= '0;
    end else begin
      res_valid <= op_valid;
      if (op_valid) res_data <= sel_word;
    end
  end

  simd_shl_csr #(.DATA_W(DATA_W), .OVF_POS(OVF_POS)) u_csr (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (csr_wr_en),
    .wr_data (csr_wr_data),
    .set_ovf (op_ovf_event),
    .q       (csr_rd_data)
  );

endmodule

// File: rtl/simd_shl_chk.sv
module simd_shl_chk #(
  parameter int DATA_W  = 32,
  parameter int OVF_POS = 22,
  parameter int SH_W    = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              op_valid,
  input logic [SH_W-1:0]   op_shamt,
  input logic [DATA_W-1:0] op_src,
  input logic              res_valid,
  input logic [DATA_W-1:0] res_data,
  input logic              csr_wr_en,
  input logic [DATA_W-1:0] csr_wr_data,
  input logic [DATA_W-1:0] csr_rd_data,
  input logic              op_ovf_event
);
  localparam logic [DATA_W-1:0] FLAG_MASK = DATA_W'(1) << OVF_POS;

  AST_RES_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid == $past(op_valid)); // R2

  AST_RES_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !op_valid |=> $stable(res_data)); // R2

  AST_FLAG_ON_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
    op_ovf_event |=> csr_rd_data[OVF_POS]); // R7

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_shamt == '0) |-> !op_ovf_event); // R7

  AST_SHIFT0_IDENT: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_shamt == '0) |=> res_data == $past(op_src)); // R7

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (!csr_wr_en && csr_rd_data[OVF_POS]) |=> csr_rd_data[OVF_POS]); // R8

  AST_FLAG_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
    (!csr_wr_en && !op_valid && !csr_rd_data[OVF_POS]) |=> !csr_rd_data[OVF_POS]); // R8

  AST_OTHER_BITS: assert property (@(posedge clk) disable iff (!rst_n)
    !csr_wr_en |=> $stable(csr_rd_data & ~FLAG_MASK)); // R8

  AST_WRITE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    csr_wr_en |=> (csr_rd_data & ~FLAG_MASK) == ($past(csr_wr_data) & ~FLAG_MASK)); // R9

endmodule

bind simd_shl_unit simd_shl_chk #(.DATA_W(DATA_W), .OVF_POS(OVF_POS), .SH_W(SH_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .op_valid     (op_valid),
  .op_shamt     (op_shamt),
  .op_src       (op_src),
  .res_valid    (res_valid),
  .res_data     (res_data),
  .csr_wr_en    (csr_wr_en),
  .csr_wr_data  (csr_wr_data),
  .csr_rd_data  (csr_rd_data),
  .op_ovf_event (op_ovf_event)
);

// File: tb/test_simd_shl_unit.sv
module test_simd_shl_unit;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        op_valid = 1'b0;
  logic        op_mode = 1'b0;
  logic [3:0]  op_shamt = '0;
  logic [31:0] op_src = '0;
  logic        res_valid;
  logic [31:0] res_data;
  logic        csr_wr_en = 1'b0;
  logic [31:0] csr_wr_data = '0;
  logic [31:0] csr_rd_data;

  always #10 clk = ~clk;

  simd_shl_unit i_simd_shl_unit (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_mode(op_mode),
    .op_shamt(op_shamt), .op_src(op_src), .res_valid(res_valid),
    .res_data(res_data), .csr_wr_en(csr_wr_en), .csr_wr_data(csr_wr_data),
    .csr_rd_data(csr_rd_data)
  );

  typedef struct {
    logic [31:0] word;
    logic [31:0] csr;
    string       tag;
  } exp_t;

  exp_t        sb[$];
  int          total = 0;
  int          bad = 0;
  bit          finished = 1'b0;
  logic [31:0] mcsr = '0;
  logic [31:0] last_word = '0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  // reference: lane value times 2**s must stay in range
  function automatic logic [31:0] ref_shift(input bit mode, input int s,
                                            input logic [31:0] src, output bit ovf);
    logic [31:0] r;
    longint      prod;
    r   = '0;
    ovf = 1'b0;
    if (!mode) begin
      for (int l = 0; l < 2; l++) begin
        prod = longint'($signed(src[16*l +: 16])) * (longint'(1) << s);
        r[16*l +: 16] = prod[15:0];
        if (prod > 32767 || prod < -32768) ovf = 1'b1;
      end
    end else begin
      for (int l = 0; l < 4; l++) begin
        prod = longint'(src[8*l +: 8]) * (longint'(1) << (s % 8));
        r[8*l +: 8] = prod[7:0];
        if (prod > 255) ovf = 1'b1;
      end
    end
    return r;
  endfunction

  // driver: present an op at a falling edge, push the expectation
  task automatic do_op(input bit mode, input int s, input logic [31:0] src,
                       input bit wr, input logic [31:0] wd, input string tag);
    exp_t e;
    bit   ov;
    @(negedge clk);
    e.word = ref_shift(mode, s, src, ov);
    if (wr) mcsr = wd;
    if (ov) mcsr[22] = 1'b1;
    e.csr = mcsr;
    e.tag = tag;
    sb.push_back(e);
    op_valid    = 1'b1;
    op_mode     = mode;
    op_shamt    = 4'(s);
    op_src      = src;
    csr_wr_en   = wr;
    csr_wr_data = wd;
  endtask

  task automatic idle();
    @(negedge clk);
    op_valid  = 1'b0;
    csr_wr_en = 1'b0;
  endtask

  task automatic write_csr(input logic [31:0] wd);
    @(negedge clk);
    op_valid    = 1'b0;
    csr_wr_en   = 1'b1;
    csr_wr_data = wd;
    mcsr        = wd;
  endtask

  task automatic check_csr(input string req);
    idle();
    chk(csr_rd_data == mcsr, req, csr_rd_data, mcsr);
  endtask

  task automatic check_quiet(input string req);
    idle();
    chk(res_valid == 1'b0, req, 32'(res_valid), 32'h0);
    chk(res_data == last_word, req, res_data, last_word);
  endtask

  // monitor
  always @(negedge clk) begin
    if (rst_n && res_valid) begin
      if (sb.size() == 0) begin
        chk(1'b0, "R2 unexpected result", res_data, 32'hx);
      end else begin
        exp_t e;
        e = sb.pop_front();
        chk(res_data == e.word, {e.tag, " data"}, res_data, e.word);
        chk(csr_rd_data == e.csr, {e.tag, " csr"}, csr_rd_data, e.csr);
        last_word = e.word;
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      bad++;
      total++;
      $display("FAIL R2 watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(res_valid == 1'b0, "R1 valid in reset", 32'(res_valid), 32'h0);
    chk(csr_rd_data == 32'h0, "R1 csr in reset", csr_rd_data, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(res_valid == 1'b0, "R1 valid after reset", 32'(res_valid), 32'h0);
    chk(csr_rd_data == 32'h0, "R1 csr after reset", csr_rd_data, 32'h0);

    // directed corner cases, each from a cleared register
    write_csr(32'h0); do_op(1'b0, 1,  32'h7FFF8000, 1'b0, 0, "R5 hw 7fff8000<<1"); idle();
    write_csr(32'h0); do_op(1'b0, 15, 32'h00000001, 1'b0, 0, "R5 hw 1<<15"); idle();
    write_csr(32'h0); do_op(1'b1, 7,  32'h00000001, 1'b0, 0, "R6 byte 1<<7"); idle();
    write_csr(32'h0); do_op(1'b1, 3,  32'h87654321, 1'b0, 0, "R6 byte 87654321<<3"); idle();
    write_csr(32'h0); do_op(1'b1, 0,  32'hFFFFFFFF, 1'b0, 0, "R7 byte shift0"); idle();
    write_csr(32'h0); do_op(1'b0, 0,  32'h80017FFF, 1'b0, 0, "R7 hw shift0"); idle();
    write_csr(32'h0); do_op(1'b1, 11, 32'h1F1F1F1F, 1'b0, 0, "R4 shamt bit3 ignored"); idle();
    write_csr(32'h0); do_op(1'b1, 1,  32'h80808080, 1'b0, 0, "R4 no byte carry"); idle();
    write_csr(32'h0); do_op(1'b0, 4,  32'hF000F000, 1'b0, 0, "R3 no half carry"); idle();
    write_csr(32'h0); do_op(1'b0, 3,  32'hF0001FFF, 1'b0, 0, "R5 top bits equal"); idle();
    check_quiet("R2 strobe drops and data holds");
    check_quiet("R2 data still held");

    // sticky flag and untouched neighbours
    write_csr(32'h1234_5678 & ~(32'h1 << 22)); check_csr("R9 write load");
    do_op(1'b1, 2, 32'hC0000000, 1'b0, 0, "R8 set keeps other bits");
    do_op(1'b1, 2, 32'h01010101, 1'b0, 0, "R8 flag stays set");
    do_op(1'b0, 0, 32'h12345678, 1'b0, 0, "R8 second clean op");
    check_csr("R8 sticky after ops");
    check_csr("R10 read without strobe");
    write_csr(32'h0); check_csr("R8 write clears flag");
    write_csr(32'hFFFFFFFF); check_csr("R9 write all ones");

    // write and overflowing op in the same cycle
    do_op(1'b0, 1, 32'h40000000, 1'b1, 32'h0000_00A5, "R9 write plus overflow");
    do_op(1'b0, 1, 32'h00010001, 1'b1, 32'h0000_0000, "R9 write plus clean op");
    idle();

    // sweep both layouts and every shift amount
    for (int m = 0; m < 2; m++) begin
      for (int s = 0; s < 16; s++) begin
        for (int k = 0; k < 3; k++) begin
          write_csr(32'h0);
          do_op(m[0], s, $urandom, 1'b0, 0, m == 0 ? "R3 R5 hw sweep" : "R4 R6 byte sweep");
          idle();
        end
      end
    end

    // back-to-back burst, flag accumulates
    write_csr(32'h0);
    for (int k = 0; k < 24; k++) begin
      do_op(k[0], k % 16, $urandom & 32'h3F3F3F3F, 1'b0, 0, "R2 R8 burst");
    end
    idle();
    check_quiet("R2 quiet after burst");
    chk(sb.size() == 0, "R2 every op answered", 32'(sb.size()), 32'h0);

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule